// File: doc/BRIEF.md
# Parallel Bus Output Control Register

This block holds the 8-bit control register that a CPU uses to steer the output side of a parallel, byte-wide peripheral bus. The CPU writes the register through a single-cycle write port and reads it back combinationally. The register bits govern several things: whether the output data latch is driven onto the bus, whether transmitted bytes carry correct odd parity or deliberately bad even parity, the level of the bus reset output, and whether an extra setup clock comes before each send strobe. One bit records whether the unit is connected to the bus. Hardware sets that bit when a connection is made, and the CPU may force it either way.

Along with the register, the block has a small transfer sequencer. A send request latches a byte and drives it on the bus for one or two setup clocks and then a one-clock strobe. A receive request produces a one-clock strobe and does not drive the bus. Three bits have no function inside this block. They are stored and read back for the logic that uses them: halt suppression (bit 5), immediate arbitration (bit 1) and start sequence (bit 0).

Top module: `busctl_unit`

## Requirements
- R1: After reset all eight register bits read 0, and `bus_rst_out`, `bus_drive_en`, `xfer_strobe` and `xfer_busy` are all 0.
- R2: A write with `reg_wr_en` high is visible on `reg_rd_data` from the next cycle, with all eight bits as written. The bit layout, from bit 7 down to bit 0, is: extra setup, drive bus, halt disable, connected, bus reset, force even parity, immediate arbitration, start sequence.
- R3: A pulse on `conn_set` without a register write sets bit 4 in the next cycle. The bit then stays at 1 until the CPU writes it to 0.
- R4: When `reg_wr_en` and `conn_set` are both high in one cycle, bit 4 takes the written value.
- R5: `bus_rst_out` equals register bit 3 for as long as the bit holds, with no time limit.
- R6: With bit 6 set and `role_target` = 0 (initiator), and no transfer in progress, `bus_drive_en` is 1 exactly when `io_in` = 0. `bus_data_out` then equals `out_latch`.
- R7: With bit 6 set and `role_target` = 1 (target), and no transfer in progress, `bus_drive_en` is 1 exactly when `io_in` = 1.
- R8: The drive in R6 and R7 does not depend on bit 4. It works while the unit is disconnected.
- R9: `bus_par_out` makes the total count of ones in {`bus_data_out`, `bus_par_out`} odd when bit 2 is 0, and even when bit 2 is 1.
- R10: A `send_req` accepted while idle raises `xfer_strobe` 2 cycles later when bit 7 was 0 at acceptance, and 3 cycles later when bit 7 was 1. The strobe is one cycle wide. From the cycle after acceptance through the strobe, `bus_drive_en` = 1 and `bus_data_out` holds the latched `send_byte`.
- R11: A `recv_req` accepted while idle raises a one-cycle `xfer_strobe` 1 cycle later whatever bit 7 holds, and does not drive the bus.
- R12: Requests that arrive while `xfer_busy` = 1 are ignored. If both requests arrive together while idle, the send request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register read data |
| conn_set | input | 1 | Hardware connection event (arbitration won or selection answered) |
| role_target | input | 1 | 1 = target role, 0 = initiator role |
| io_in | input | 1 | Bus I/O direction line, 1 = active |
| out_latch | input | 8 | Output data latch contents |
| send_req | input | 1 | Start a send transfer |
| recv_req | input | 1 | Start a receive transfer |
| send_byte | input | 8 | Byte to send |
| bus_data_out | output | 8 | Data toward the bus drivers |
| bus_par_out | output | 1 | Parity bit toward the bus |
| bus_drive_en | output | 1 | Bus driver enable |
| bus_rst_out | output | 1 | Bus reset output |
| xfer_strobe | output | 1 | Transfer strobe pulse |
| xfer_busy | output | 1 | Transfer in progress |

## Verification
A corrupted register bit shows up on `reg_rd_data` in the cycle after the write that set it. Corrupted bits 3, 6 and 2 also show up, in that same cycle, on the reset, driver-enable and parity pins. A sequencer that is stuck or that counts wrongly shows up as a strobe that comes one cycle early or late, or that lasts more than one cycle. The bench measures strobe timing to the exact cycle, for both settings of the setup bit. A bad connected-flag merge shows up one cycle after a `conn_set` pulse, and the bench checks it both with and without a write in the same cycle.

// File: rtl/busctl_pkg.sv
package busctl_pkg;

    // Field order (bit 7 down to bit 0) is the software-visible layout.
    typedef struct packed {
        logic xsetup;    // 7: extra setup clock on sends
        logic drv_bus;   // 6: drive output latch onto bus
        logic no_halt;   // 5: halt suppression (stored only)
        logic linked;    // 4: connected flag
        logic bus_rst;   // 3: bus reset output level
        logic par_even;  // 2: force even (bad) parity
        logic imm_arb;   // 1: immediate arbitration (stored only)
        logic seq_go;    // 0: start sequence (stored only)
    } ctl_reg_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP_A,
        SQ_SETUP_B,
        SQ_SEND_STB,
        SQ_RECV_STB
    } seq_state_e;

endpackage

// File: rtl/busctl_regs.sv
module busctl_regs
    import busctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       conn_set,
    output ctl_reg_t   ctl_q
);

    typedef struct packed {
        ctl_reg_t ctl;
    } regs_t;

    regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (wr_en) begin
            nxt_d.ctl = ctl_reg_t'(wr_data);
        end else if (conn_set) begin
            nxt_d.ctl.linked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ctl_q = cur_q.ctl;

    // R2
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctl_q == $past(wr_data)));

    // R3
    conn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && conn_set) |=> ctl_q.linked);

    // R4
    cpu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && conn_set && !wr_data[4]) |=> !ctl_q.linked);

endmodule

// File: rtl/busctl_seq.sv
module busctl_seq
    import busctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xsetup,
    input  logic              send_req,
    input  logic              recv_req,
    input  logic [DATA_W-1:0] send_byte,
    output logic              seq_busy,
    output logic              seq_drive,
    output logic              seq_strobe,
    output logic [DATA_W-1:0] seq_data
);

    typedef struct packed {
        seq_state_e        st;
        logic              xs;
        logic [DATA_W-1:0] data;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            SQ_IDLE: begin
                if (send_req) begin
                    nxt_d.st   = SQ_SETUP_A;
                    nxt_d.xs   = xsetup;
                    nxt_d.data = send_byte;
                end else if (recv_req) begin
                    nxt_d.st = SQ_RECV_STB;
                end
            end
            SQ_SETUP_A:  nxt_d.st = cur_q.xs ? SQ_SETUP_B : SQ_SEND_STB;
            SQ_SETUP_B:  nxt_d.st = SQ_SEND_STB;
            SQ_SEND_STB: nxt_d.st = SQ_IDLE;
            SQ_RECV_STB: nxt_d.st = SQ_IDLE;
            default:     nxt_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: SQ_IDLE, xs: 1'b0, data: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign seq_busy   = (cur_q.st != SQ_IDLE);
    assign seq_drive  = (cur_q.st == SQ_SETUP_A) || (cur_q.st == SQ_SETUP_B) ||
                        (cur_q.st == SQ_SEND_STB);
    assign seq_strobe = (cur_q.st == SQ_SEND_STB) || (cur_q.st == SQ_RECV_STB);
    assign seq_data   = cur_q.data;

    // R10
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_strobe |=> !seq_strobe);

    // R12
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && !seq_strobe) |=> (seq_busy && $stable(seq_data)));

    // R11
    recv_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_strobe && !seq_drive) |-> ($past(recv_req) && !$past(seq_busy)));

endmodule

// File: rtl/busctl_drive.sv
module busctl_drive #(
    parameter int DATA_W = 8
) (
    input  logic              drv_bus,
    input  logic              par_even,
    input  logic              role_target,
    input  logic              io_in,
    input  logic [DATA_W-1:0] latch_data,
    input  logic              seq_drive,
    input  logic [DATA_W-1:0] seq_data,
    output logic              drive_en,
    output logic [DATA_W-1:0] data_out,
    output logic              par_out
);

    logic io_ok;
    logic [DATA_W:0] xchain;

    // Role gating: initiator drives with I/O inactive, target with I/O active.
    assign io_ok    = role_target ? io_in : ~io_in;
    assign drive_en = seq_drive | (drv_bus & io_ok);
    assign data_out = seq_drive ? seq_data : latch_data;

    assign xchain[0] = 1'b0;
    for (genvar i = 0; i < DATA_W; i++) begin : g_par
        assign xchain[i+1] = xchain[i] ^ data_out[i];
    end

    // Odd parity inverts the XOR; forced even parity leaves it as is.
    assign par_out = xchain[DATA_W] ^ ~par_even;

endmodule

// File: rtl/busctl_unit.sv
module busctl_unit
    import busctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic [7:0] reg_wr_data,
    output logic [7:0] reg_rd_data,
    input  logic       conn_set,
    input  logic       role_target,
    input  logic       io_in,
    input  logic [7:0] out_latch,
    input  logic       send_req,
    input  logic       recv_req,
    input  logic [7:0] send_byte,
    output logic [7:0] bus_data_out,
    output logic       bus_par_out,
    output logic       bus_drive_en,
    output logic       bus_rst_out,
    output logic       xfer_strobe,
    output logic       xfer_busy
);

    localparam int DATA_W = 8;

    ctl_reg_t          ctl;
    logic              seq_drive;
    logic [DATA_W-1:0] seq_data;

    busctl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .conn_set(conn_set),
        .ctl_q   (ctl)
    );

    busctl_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .xsetup    (ctl.xsetup),
        .send_req  (send_req),
        .recv_req  (recv_req),
        .send_byte (send_byte),
        .seq_busy  (xfer_busy),
        .seq_drive (seq_drive),
        .seq_strobe(xfer_strobe),
        .seq_data  (seq_data)
    );

    busctl_drive #(.DATA_W(DATA_W)) u_drive (
        .drv_bus    (ctl.drv_bus),
        .par_even   (ctl.par_even),
        .role_target(role_target),
        .io_in      (io_in),
        .latch_data (out_latch),
        .seq_drive  (seq_drive),
        .seq_data   (seq_data),
        .drive_en   (bus_drive_en),
        .data_out   (bus_data_out),
        .par_out    (bus_par_out)
    );

    assign reg_rd_data = ctl;
    assign bus_rst_out = ctl.bus_rst;

    // R5
    rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_en |=> $stable(bus_rst_out));

    // R6
    no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.drv_bus && !xfer_busy) |-> !bus_drive_en);

    // R9
    parity_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive_en |-> ((^{bus_data_out, bus_par_out}) == !ctl.par_even));

    // R10
    send_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && !$past(xfer_busy) && $past(send_req)) |-> bus_drive_en);

endmodule

// File: tb/busctl_unit_tb_top.sv
module busctl_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = '0;
    logic [7:0] reg_rd_data;
    logic       conn_set = 1'b0;
    logic       role_target = 1'b0;
    logic       io_in = 1'b0;
    logic [7:0] out_latch = '0;
    logic       send_req = 1'b0;
    logic       recv_req = 1'b0;
    logic [7:0] send_byte = '0;
    logic [7:0] bus_data_out;
    logic       bus_par_out;
    logic       bus_drive_en;
    logic       bus_rst_out;
    logic       xfer_strobe;
    logic       xfer_busy;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    busctl_unit dut_i (.*);

    function automatic logic exp_par(input logic [7:0] b, input logic even);
        return even ? (^b) : ~(^b);
    endfunction

    function automatic logic exp_drive(input logic adb, input logic tgt, input logic io);
        return adb && (tgt ? io : !io);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wr_en   = 1'b1;
        reg_wr_data = v;
        tick();
        reg_wr_en   = 1'b0;
    endtask

    // Issues one request; returns cycles to strobe plus data and drive at strobe.
    task automatic xfer(input logic is_recv, input logic [7:0] b,
                        output int lat, output logic [7:0] dat, output logic drv);
        if (is_recv) recv_req = 1'b1; else send_req = 1'b1;
        send_byte = b;
        tick();
        send_req = 1'b0;
        recv_req = 1'b0;
        lat = 1;
        while (!xfer_strobe && lat < 10) begin
            tick();
            lat++;
        end
        dat = bus_data_out;
        drv = bus_drive_en;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        logic [7:0] dat;
        logic drv;
        void'($urandom(32'h5eed_1234));

        repeat (3) tick();
        // R1 reset state
        chk("R1 rd", reg_rd_data, 8'h00);
        chk("R1 rst_out", bus_rst_out, 1'b0);
        chk("R1 drive_en", bus_drive_en, 1'b0);
        chk("R1 strobe", xfer_strobe, 1'b0);
        chk("R1 busy", xfer_busy, 1'b0);
        rst_n = 1'b1;
        tick();

        // R2 / R5 random write readback
        for (int i = 0; i < 40; i++) begin
            logic [7:0] v;
            v = 8'($urandom);
            wr(v);
            chk("R2 readback", reg_rd_data, v);
            chk("R5 rst_out", bus_rst_out, v[3]);
        end

        // R5 long hold
        wr(8'h08);
        repeat (200) tick();
        chk("R5 held", bus_rst_out, 1'b1);
        wr(8'h00);
        chk("R5 released", bus_rst_out, 1'b0);

        // R3 hardware connect
        conn_set = 1'b1;
        tick();
        conn_set = 1'b0;
        chk("R3 set", reg_rd_data[4], 1'b1);
        repeat (5) tick();
        chk("R3 sticky", reg_rd_data[4], 1'b1);
        wr(8'h00);
        chk("R3 cleared by cpu", reg_rd_data[4], 1'b0);

        // R4 same-cycle collision
        conn_set = 1'b1;
        wr(8'h00);
        conn_set = 1'b0;
        chk("R4 write 0 wins", reg_rd_data[4], 1'b0);
        conn_set = 1'b1;
        wr(8'h10);
        conn_set = 1'b0;
        chk("R4 write 1", reg_rd_data[4], 1'b1);

        // R6 / R7 / R8 directed corners, disconnected
        wr(8'h40);
        out_latch = 8'hA5;
        role_target = 1'b0; io_in = 1'b0; #1;
        chk("R8 drive while disconnected", bus_drive_en, 1'b1);
        chk("R6 data", bus_data_out, 8'hA5);
        io_in = 1'b1; #1;
        chk("R6 initiator io active", bus_drive_en, 1'b0);
        role_target = 1'b1; #1;
        chk("R7 target io active", bus_drive_en, 1'b1);
        io_in = 1'b0; #1;
        chk("R7 target io inactive", bus_drive_en, 1'b0);

        // R9 parity corners
        role_target = 1'b0; io_in = 1'b0;
        out_latch = 8'h00; #1;
        chk("R9 odd 00", bus_par_out, 1'b1);
        out_latch = 8'hFF; #1;
        chk("R9 odd FF", bus_par_out, 1'b1);
        wr(8'h44);
        chk("R9 even FF", bus_par_out, 1'b0);
        out_latch = 8'h01; #1;
        chk("R9 even 01", bus_par_out, 1'b1);

        // R6 R7 R8 R9 random
        for (int i = 0; i < 300; i++) begin
            logic [7:0] v;
            v = 8'($urandom) & 8'h7F;
            wr(v);
            role_target = 1'($urandom);
            io_in       = 1'($urandom);
            out_latch   = 8'($urandom);
            #1;
            chk("R6/R7 random drive", bus_drive_en, exp_drive(v[6], role_target, io_in));
            chk("R9 random parity", bus_par_out, exp_par(out_latch, v[2]));
            chk("R6 random data", bus_data_out, out_latch);
            tick();
        end

        // R10 / R11 directed
        wr(8'h00);
        out_latch = 8'h3C;
        xfer(1'b0, 8'h5A, lat, dat, drv);
        chk("R10 latency no extra", lat, 2);
        chk("R10 data", dat, 8'h5A);
        chk("R10 drive", drv, 1'b1);
        tick();
        chk("R10 one wide", xfer_strobe, 1'b0);
        wr(8'h80);
        xfer(1'b0, 8'hC3, lat, dat, drv);
        chk("R10 latency extra", lat, 3);
        chk("R10 data extra", dat, 8'hC3);
        tick();
        chk("R10 one wide extra", xfer_strobe, 1'b0);
        xfer(1'b1, 8'h00, lat, dat, drv);
        chk("R11 recv latency", lat, 1);
        chk("R11 recv no drive", drv, 1'b0);
        tick();

        // R12 request while busy ignored
        send_req = 1'b1; send_byte = 8'h11;
        tick();
        send_byte = 8'h22;
        recv_req = 1'b1;
        tick();
        send_req = 1'b0; recv_req = 1'b0;
        tick();
        chk("R12 first strobe", xfer_strobe, 1'b1);
        chk("R12 data kept", bus_data_out, 8'h11);
        tick();
        chk("R12 idle after", xfer_busy, 1'b0);
        repeat (4) begin
            tick();
            chk("R12 no extra strobe", xfer_strobe, 1'b0);
        end
        // R12 priority
        send_req = 1'b1; recv_req = 1'b1; send_byte = 8'h77;
        tick();
        send_req = 1'b0; recv_req = 1'b0;
        chk("R12 send wins drive", bus_drive_en, 1'b1);
        repeat (4) tick();

        // R10 / R11 random
        for (int i = 0; i < 40; i++) begin
            logic ex, rv;
            logic [7:0] b;
            ex = 1'($urandom);
            rv = 1'($urandom);
            b  = 8'($urandom);
            wr({ex, 7'h00});
            xfer(rv, b, lat, dat, drv);
            if (rv) begin
                chk("R11 random latency", lat, 1);
                chk("R11 random no drive", drv, 1'b0);
            end else begin
                chk("R10 random latency", lat, ex ? 3 : 2);
                chk("R10 random data", dat, b);
            end
            tick();
            chk("R10 random one wide", xfer_strobe, 1'b0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule